// File: doc/BRIEF.md
# Multi-Channel Button Debouncer with Press Strobe

This block cleans up a vector of raw, unclocked button or switch lines. Each line is first brought into the clock domain through two flip-flops in series. A single free-running divider produces one sample tick every `SAMPLE_CYCLES` clocks, and every channel shares that tick. A channel is accepted as pressed only after its synchronized line has been seen high on `PRESS_SAMPLES` ticks with no low cycle in between. A single low cycle at any point sets that channel's progress back to zero.

For each channel the block drives a clean level, which is high while the channel is accepted as pressed. It also drives a strobe that is exactly one clock wide on every rising edge of that level. The surrounding logic uses the strobe as a "key pressed once" event and the level as a "key held" indication. The channel count, the tick interval and the number of samples needed are all parameters.

Top module: `btnDebounce`

## Requirements
- R1: A synchronous active-high `rst` clears the synchronizer flops, the tick divider, every channel's sample counter and every strobe history flop. From the first clock edge after `rst` is sampled high, all `level` and `pulse` bits read 0.
- R2: A change on `rawIn[i]` reaches channel i's counter only after two register stages. When a saturated channel's raw line goes low before clock edge t, `level[i]` is still 1 after edges t and t+1 and is 0 after edge t+2.
- R3: One shared tick fires on the SAMPLE_CYCLES-th clock edge after reset and on every SAMPLE_CYCLES-th edge after that, for all channels alike.
- R4: A channel's counter advances by one only on an edge where the tick is active and that channel's synchronized line is 1.
- R5: On any edge where a channel's synchronized line is 0, its counter returns to 0, whether or not a tick occurs.
- R6: When a counter reaches PRESS_SAMPLES it stays there for as long as the synchronized line stays 1.
- R7: `level[i]` is 1 exactly when channel i's counter equals PRESS_SAMPLES.
- R8: `pulse[i]` is 1 for exactly the one cycle after each 0-to-1 change of `level[i]`, whether the level stays high for one cycle or for many.
- R9: A line that goes low before PRESS_SAMPLES ticks have been collected never produces a `level` or `pulse` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rawIn | input | NUM_CH | Raw asynchronous button lines |
| level | output | NUM_CH | Debounced level per channel |
| pulse | output | NUM_CH | One-cycle strobe on each debounced rise |

## Verification
If a channel's counter holds a wrong value, `level` rises early, rises late or fails to rise. The error shows within one tick interval of the step that went wrong, as a shifted rise edge. If the tick phase is wrong, the rise edge of every channel moves by the same number of cycles. A stale strobe history shows up on the very next clock edge, as a strobe that is missing, doubled or held on. A short synchronizer chain shows up on the cycle a saturated level falls, which comes one edge too early.

// File: rtl/btn_pkg.sv
package btn_pkg;
  // Strobes from the control unit to the per-channel datapath.
  typedef struct packed {
    logic sampleTick;
  } btnStrobe_t;

  function automatic int unsigned widthFor(input int unsigned maxVal);
    return (maxVal > 1) ? $clog2(maxVal + 1) : 1;
  endfunction
endpackage

// File: rtl/btnSync.sv
module btnSync #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rawIn,
  output logic [NUM_CH-1:0] syncOut
);
  logic [NUM_CH-1:0] stageA;

  // Two flops in series: the first may go metastable, the second settles it.
  always_ff @(posedge clk) begin
    if (rst) begin
      stageA  <= '0;
      syncOut <= '0;
    end else begin
      stageA  <= rawIn;
      syncOut <= stageA;
    end
  end
endmodule

// File: rtl/btnCtrl.sv
module btnCtrl
  import btn_pkg::*;
#(
  parameter int unsigned SAMPLE_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst,
  output btnStrobe_t strobe
);
  localparam int unsigned DIV_W = widthFor(SAMPLE_CYCLES - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_CYCLES - 1);

  logic [DIV_W-1:0] divCnt;
  logic             atLast;

  assign atLast = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || atLast) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobe            = '0;
    strobe.sampleTick = atLast;
  end
endmodule

// File: rtl/btnDatapath.sv
module btnDatapath
  import btn_pkg::*;
#(
  parameter int unsigned NUM_CH        = 4,
  parameter int unsigned PRESS_SAMPLES = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  btnStrobe_t        strobe,
  input  logic [NUM_CH-1:0] syncIn,
  output logic [NUM_CH-1:0] level,
  output logic [NUM_CH-1:0] pulse
);
  localparam int unsigned CNT_W = widthFor(PRESS_SAMPLES);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PRESS_SAMPLES);

  logic [NUM_CH-1:0] levelPrev;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] hitCnt;
    logic             saturated;

    assign saturated = (hitCnt == CNT_TOP);

    always_ff @(posedge clk) begin
      if (rst || !syncIn[ch])                     hitCnt <= '0;
      else if (strobe.sampleTick && !saturated)   hitCnt <= hitCnt + 1'b1;
    end

    assign level[ch] = saturated;
  end

  // Rising-edge detector on the clean levels.
  always_ff @(posedge clk) begin
    if (rst) levelPrev <= '0;
    else     levelPrev <= level;
  end

  assign pulse = level & ~levelPrev;
endmodule

// File: rtl/btnDebounce.sv
module btnDebounce
  import btn_pkg::*;
#(
  parameter int unsigned NUM_CH        = 4,
  parameter int unsigned SAMPLE_CYCLES = 25000,
  parameter int unsigned PRESS_SAMPLES = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rawIn,
  output logic [NUM_CH-1:0] level,
  output logic [NUM_CH-1:0] pulse
);
  logic [NUM_CH-1:0] syncIn;
  btnStrobe_t        strobe;

  btnSync #(.NUM_CH(NUM_CH)) u_sync (
    .clk(clk), .rst(rst), .rawIn(rawIn), .syncOut(syncIn)
  );

  btnCtrl #(.SAMPLE_CYCLES(SAMPLE_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe)
  );

  btnDatapath #(.NUM_CH(NUM_CH), .PRESS_SAMPLES(PRESS_SAMPLES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .syncIn(syncIn),
    .level(level), .pulse(pulse)
  );
endmodule

// File: rtl/btnDebounce_checker.sv
module btnDebounce_checker #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] rawIn,
  input logic [NUM_CH-1:0] level,
  input logic [NUM_CH-1:0] pulse
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (level == '0 && pulse == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_fall_after_low_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(level[ch]) |-> !$past(rawIn[ch], 3));

    assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
      pulse[ch] |-> (level[ch] && !$past(level[ch])));

    assert_rise_has_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(level[ch]) |-> pulse[ch]);

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
      pulse[ch] |=> !pulse[ch]);

    assert_level_needs_input_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(level[ch]) |-> $past(rawIn[ch], 3));
  end
endmodule

bind btnDebounce btnDebounce_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk(clk), .rst(rst), .rawIn(rawIn), .level(level), .pulse(pulse)
);

// File: tb/btnDebounce_bench.sv
module btnDebounce_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int SMP = 3;
  localparam int PRS = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] rawIn = '0;
  logic [NCH-1:0] level;
  logic [NCH-1:0] pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btnDebounce #(.NUM_CH(NCH), .SAMPLE_CYCLES(SMP), .PRESS_SAMPLES(PRS)) u_btnDebounce (
    .clk(clk), .rst(rst), .rawIn(rawIn), .level(level), .pulse(pulse)
  );

  // Behavioural expectation built from the requirements, stepped per edge.
  logic [NCH-1:0] mS1 = '0, mS2 = '0, mPrev = '0;
  int mCnt [NCH];
  int mEdge = 0;
  initial for (int i = 0; i < NCH; i++) mCnt[i] = 0;

  always @(posedge clk) begin
    logic [NCH-1:0] curLvl;
    bit tick;
    for (int i = 0; i < NCH; i++) curLvl[i] = (mCnt[i] == PRS);
    if (rst) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mEdge = 0;
      for (int i = 0; i < NCH; i++) mCnt[i] = 0;
    end else begin
      mEdge = mEdge + 1;
      tick  = (mEdge % SMP) == 0;                 // R3 shared tick
      for (int i = 0; i < NCH; i++) begin
        if (!mS2[i])                    mCnt[i] = 0;            // R5
        else if (tick && mCnt[i] < PRS) mCnt[i] = mCnt[i] + 1;  // R4, R6
      end
      mPrev = curLvl;
      mS2 = mS1; mS1 = rawIn;                                    // R2
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the expectation (R7, R8).
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < NCH; i++) begin
        int eLvl;
        eLvl = (mCnt[i] == PRS) ? 1 : 0;
        check("R7 level", int'(level[i]), eLvl);
        check("R8 pulse", int'(pulse[i]), (eLvl == 1 && !mPrev[i]) ? 1 : 0);
      end
    end
  end

  task automatic doReset();
    @(negedge clk); rst = 1'b1; rawIn = '0;
    repeat (2) @(negedge clk);
    check("R1 level", int'(level), 0);
    check("R1 pulse", int'(pulse), 0);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int firstTick, riseEdge, pulses;
    bit sawHigh;
    doReset();

    // R3 R4: clean press from reset; predicted rise edge computed arithmetically.
    rawIn[0] = 1'b1;
    firstTick = ((3 + SMP - 1) / SMP) * SMP;
    riseEdge  = firstTick + (PRS - 1) * SMP;
    repeat (riseEdge - 1) @(negedge clk);
    check("R4 early level", int'(level[0]), 0);
    @(negedge clk);
    check("R3 rise edge", int'(level[0]), 1);
    check("R8 pulse at rise", int'(pulse[0]), 1);
    @(negedge clk);
    check("R8 pulse width", int'(pulse[0]), 0);
    // R6 hold while high
    repeat (5 * SMP) @(negedge clk);
    check("R6 saturate hold", int'(level[0]), 1);
    // R2 two-stage latency on release
    rawIn[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 still high", int'(level[0]), 1);
    @(negedge clk);
    check("R2 falls", int'(level[0]), 0);

    // R9 R5: bounce with low gaps shorter than PRS samples never rises.
    sawHigh = 1'b0;
    for (int rep = 0; rep < 12; rep++) begin
      rawIn[1] = 1'b1;
      for (int k = 0; k < (PRS - 1) * SMP; k++) begin
        @(negedge clk); sawHigh |= level[1] | pulse[1];
      end
      rawIn[1] = 1'b0;
      @(negedge clk); sawHigh |= level[1] | pulse[1];
    end
    repeat (4) begin @(negedge clk); sawHigh |= level[1] | pulse[1]; end
    check("R9 bounce ignored", int'(sawHigh), 0);

    // Sweep hold lengths on channel 2; pulses counted versus per-edge model.
    for (int len = 1; len <= 4 * SMP * PRS; len++) begin
      doReset();
      pulses = 0;
      rawIn[2] = 1'b1;
      for (int k = 0; k < len; k++) begin @(negedge clk); pulses += pulse[2]; end
      rawIn[2] = 1'b0;
      for (int k = 0; k < 4; k++) begin @(negedge clk); pulses += pulse[2]; end
      firstTick = ((3 + SMP - 1) / SMP) * SMP;
      riseEdge  = firstTick + (PRS - 1) * SMP;
      // line is seen by the counter on edges 3..len+2
      check("R9 sweep pulses", pulses, (len + 2 >= riseEdge) ? 1 : 0);
    end

    // Pseudo-random chatter on all channels, compared every cycle.
    doReset();
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[3:0] == 4'h0) rawIn = lfsr[NCH+3:4];
        if (c % 400 == 0) rawIn = '1;
      end
    end
    rawIn = '0;
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule